// File: doc/BRIEF.md
# Race Start Sequencer

This block is the control core of a race timer. It runs entirely on one fast system clock and derives its slow rates (one second per countdown step, a 125 ms LED toggle) from internal cycle counters, never from divided clocks. A reset button forces it back to an idle, ready state. A second button has two meanings. While idle, it starts the race. While the race is running, it reports an athlete crossing the line.

After a start press, the sequencer shows a countdown of 3, 2, 1, 0 on one display digit, spending one second on each value. During the countdown it asks that all other digits be blanked and holds the stopwatch cleared. When the zero step ends, it releases the stopwatch to count up. While running, each press of the shared button becomes a one-cycle finish event for the capture logic downstream. When the stopwatch reports that it has saturated, the sequencer stops it and flashes every LED together at 4 Hz until reset.

The stopwatch arithmetic, finish-time capture and segment decoding live in other blocks. This block only supplies the controls and the countdown digit that those blocks use.

Top module: `race_sequencer`

## Requirements
- R1: About two cycles after the reset button is released, the block is idle. In idle, `sw_clear`=1, `sw_run`=0, `cd_show`=0, `blank_others`=0, `finish_pulse`=0 and `led`=0.
- R2: A press (`go_btn_n` driven low) while idle starts the countdown: `cd_show`=1, `blank_others`=1 and `cd_digit`=3. These appear after the third rising clock edge that follows the input change (two synchroniser stages plus the state register).
- R3: The countdown digit takes the values 3, 2, 1, 0 in that order. Each value is held for exactly SEC_DIV cycles.
- R4: After zero has been shown for SEC_DIV cycles, the block runs: `sw_run`=1, `sw_clear`=0, `cd_show`=0, `blank_others`=0. `sw_run` and `sw_clear` are never high together.
- R5: `sw_clear` is high in idle and throughout the countdown.
- R6: Presses during the countdown are ignored. The digit sequence and its timing are unchanged, and no `finish_pulse` is produced.
- R7: Each press while running produces exactly one single-cycle `finish_pulse`, three edges after the input change, however long the button is held. The block stays in the running state. `finish_pulse` is never high unless the block was running on the previous cycle.
- R8: `sat_in`=1 while running takes the block to saturation on the next edge: `sw_run`=0, `sw_clear`=0. All LED bits then carry the same value. They start on and toggle every FLASH_DIV cycles.
- R9: Saturation persists, with the LEDs still flashing, until reset. It persists regardless of button presses and of `sat_in` going low.
- R10: Driving `rst_btn_n` low forces the idle outputs of R1 at once, in any state, without waiting for a clock edge.
- R11: `sat_in` has no effect outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst_btn_n | input | 1 | Reset button, low when pressed; asserts asynchronously, releases synchronously |
| go_btn_n | input | 1 | Shared start/finish button, low when pressed, asynchronous |
| sat_in | input | 1 | Stopwatch has reached its maximum value |
| sw_clear | output | 1 | Holds the stopwatch at zero |
| sw_run | output | 1 | Enables stopwatch counting |
| finish_pulse | output | 1 | One-cycle finish event for the capture block |
| cd_show | output | 1 | Countdown digit is to be displayed |
| cd_digit | output | 4 | Countdown value (3 down to 0) |
| blank_others | output | 1 | Blank every digit except the countdown digit |
| led | output | LED_N | Alarm LEDs, all bits equal |

## Verification
Some properties are checked by the assertions on every cycle:
- the countdown digit only ever steps down by one and stays within range;
- the stopwatch is never cleared and enabled at once;
- finish events last a single cycle and occur only after a running cycle;
- the LEDs always move as one group;
- saturation, once reached, never leaves except through reset.

Other properties depend on counting cycles against the parameters, and only the bench scenarios can show them: the exact hold time of each countdown value, the latency through the button synchroniser, the LED on/off durations, and the immunity to presses and to `sat_in` outside the states where they matter.

// File: rtl/race_sequencer.sv
module race_sequencer #(
  parameter int unsigned SEC_DIV   = 50_000_000,
  parameter int unsigned FLASH_DIV = 6_250_000,
  parameter int unsigned CD_START  = 3,
  parameter int unsigned LED_N     = 10
) (
  input  logic             clk,
  input  logic             rst_btn_n,
  input  logic             go_btn_n,
  input  logic             sat_in,
  output logic             sw_clear,
  output logic             sw_run,
  output logic             finish_pulse,
  output logic             cd_show,
  output logic [3:0]       cd_digit,
  output logic             blank_others,
  output logic [LED_N-1:0] led
);
  localparam int SW = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
  localparam int FW = (FLASH_DIV > 1) ? $clog2(FLASH_DIV) : 1;
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_DIV - 1);
  localparam logic [FW-1:0] FL_LAST  = FW'(FLASH_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_CD, S_RUN, S_SAT} st_t;

  st_t           st;
  logic [1:0]    rsync;
  logic [2:0]    gsync;
  logic [SW-1:0] sec_cnt;
  logic [FW-1:0] fl_cnt;
  logic          flash_on;
  logic          rst_n, press;

  always_ff @(posedge clk or negedge rst_btn_n)
    if (!rst_btn_n) rsync <= '0;
    else            rsync <= {rsync[0], 1'b1};
  assign rst_n = rsync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gsync <= '0;
    else        gsync <= {gsync[1:0], ~go_btn_n};
  assign press = gsync[1] & ~gsync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cd_digit     <= '0;
      sec_cnt      <= '0;
      fl_cnt       <= '0;
      flash_on     <= 1'b0;
      finish_pulse <= 1'b0;
    end else begin
      finish_pulse <= press && (st == S_RUN);
      case (st)
        S_IDLE:
          if (press) begin
            st       <= S_CD;
            cd_digit <= 4'(CD_START);
            sec_cnt  <= '0;
          end
        S_CD:
          if (sec_cnt == SEC_LAST) begin
            sec_cnt <= '0;
            if (cd_digit == 4'd0) st <= S_RUN;
            else                  cd_digit <= cd_digit - 4'd1;
          end else begin
            sec_cnt <= sec_cnt + 1'b1;
          end
        S_RUN:
          if (sat_in) begin
            st       <= S_SAT;
            fl_cnt   <= '0;
            flash_on <= 1'b1;
          end
        default:
          if (fl_cnt == FL_LAST) begin
            fl_cnt   <= '0;
            flash_on <= ~flash_on;
          end else begin
            fl_cnt <= fl_cnt + 1'b1;
          end
      endcase
    end
  end

  assign sw_clear     = (st == S_IDLE) || (st == S_CD);
  assign sw_run       = (st == S_RUN);
  assign cd_show      = (st == S_CD);
  assign blank_others = (st == S_CD);
  assign led          = {LED_N{(st == S_SAT) && flash_on}};
endmodule

// File: rtl/race_sequencer_chk.sv
module race_sequencer_chk #(
  parameter int unsigned LED_N = 10
) (
  input logic             clk,
  input logic             rst_btn_n,
  input logic             sw_clear,
  input logic             sw_run,
  input logic             finish_pulse,
  input logic             cd_show,
  input logic [3:0]       cd_digit,
  input logic [LED_N-1:0] led
);
  assert_cd_range_R3: assert property (@(posedge clk) disable iff (!rst_btn_n)
    cd_show |-> cd_digit <= 4'd3);
  assert_cd_step_R3: assert property (@(posedge clk) disable iff (!rst_btn_n)
    (cd_show && $past(cd_show) && cd_digit != $past(cd_digit)) |-> cd_digit == $past(cd_digit) - 4'd1);
  assert_run_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_btn_n)
    !(sw_run && sw_clear));
  assert_cd_holds_clear_R5: assert property (@(posedge clk) disable iff (!rst_btn_n)
    cd_show |-> sw_clear);
  assert_finish_single_R7: assert property (@(posedge clk) disable iff (!rst_btn_n)
    finish_pulse |=> !finish_pulse);
  assert_finish_after_run_R7: assert property (@(posedge clk) disable iff (!rst_btn_n)
    finish_pulse |-> $past(sw_run));
  assert_leds_together_R8: assert property (@(posedge clk) disable iff (!rst_btn_n)
    (led == '0) || (led == '1));
  assert_leds_only_sat_R8: assert property (@(posedge clk) disable iff (!rst_btn_n)
    (led != '0) |-> (!sw_run && !sw_clear));
  assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_btn_n)
    (!sw_run && !sw_clear) |=> (!sw_run && !sw_clear));
endmodule

bind race_sequencer race_sequencer_chk #(.LED_N(LED_N)) u_chk (
  .clk(clk), .rst_btn_n(rst_btn_n), .sw_clear(sw_clear), .sw_run(sw_run),
  .finish_pulse(finish_pulse), .cd_show(cd_show), .cd_digit(cd_digit), .led(led)
);

// File: tb/race_sequencer_test.sv
module race_sequencer_test;
  localparam int SEC_DIV = 16;
  localparam int FLASH_DIV = 6;
  localparam int LED_N = 10;
  localparam int CD_TBL [4] = '{3, 2, 1, 0};

  logic clk = 1'b0;
  logic rst_btn_n = 1'b0, go_btn_n = 1'b1, sat_in = 1'b0;
  logic sw_clear, sw_run, finish_pulse, cd_show, blank_others;
  logic [3:0] cd_digit;
  logic [LED_N-1:0] led;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  race_sequencer #(.SEC_DIV(SEC_DIV), .FLASH_DIV(FLASH_DIV), .LED_N(LED_N)) uut (
    .clk(clk), .rst_btn_n(rst_btn_n), .go_btn_n(go_btn_n), .sat_in(sat_in),
    .sw_clear(sw_clear), .sw_run(sw_run), .finish_pulse(finish_pulse),
    .cd_show(cd_show), .cd_digit(cd_digit), .blank_others(blank_others), .led(led));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(sw_clear && !sw_run && !cd_show && !blank_others && !finish_pulse && led == '0, req,
        {sw_clear, sw_run, cd_show, blank_others, finish_pulse, |led}, 6'b100000);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt, pulses, ons;
    bit stray;
    cyc(3);
    chk_idle("R10 held reset");
    rst_btn_n = 1'b1;
    cyc(4);
    chk_idle("R1 idle after reset");

    sat_in = 1'b1; cyc(4);
    chk_idle("R11 sat_in in idle");
    sat_in = 1'b0; cyc(2);

    go_btn_n = 1'b0;
    cyc(2);
    chk(!cd_show, "R2 not before third edge", cd_show, 0);
    cyc(1);
    chk(cd_show && blank_others && cd_digit == 4'd3, "R2 countdown start", cd_digit, 3);
    chk(sw_clear, "R5 clear at countdown start", sw_clear, 1);

    stray = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cnt = 1;
      forever begin
        @(negedge clk);
        if (finish_pulse || !sw_clear && cd_show) stray = 1'b1;
        if (i == 1 && cnt == 2) go_btn_n = 1'b1;
        if (i == 1 && cnt == 6) go_btn_n = 1'b0;
        if (cd_show && cd_digit == 4'(CD_TBL[i])) cnt++;
        else break;
      end
      chk(cnt == SEC_DIV, $sformatf("R3 hold of digit %0d", CD_TBL[i]), cnt, SEC_DIV);
    end
    chk(!stray, "R6 press ignored / R5 clear held in countdown", stray, 0);
    chk(sw_run && !sw_clear && !cd_show && !blank_others, "R4 running after zero",
        {sw_run, sw_clear, cd_show, blank_others}, 4'b1000);

    go_btn_n = 1'b1; cyc(4);
    chk(!finish_pulse, "R6 no pulse from countdown press", finish_pulse, 0);
    go_btn_n = 1'b0;
    cyc(2);
    chk(!finish_pulse, "R7 pulse not early", finish_pulse, 0);
    cyc(1);
    chk(finish_pulse, "R7 pulse on third edge", finish_pulse, 1);
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      cyc(1);
      if (finish_pulse) pulses++;
    end
    chk(pulses == 0, "R7 held press gives one pulse", pulses, 0);
    chk(sw_run, "R7 still running", sw_run, 1);
    go_btn_n = 1'b1; cyc(4); go_btn_n = 1'b0;
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      cyc(1);
      if (finish_pulse) pulses++;
    end
    chk(pulses == 1, "R7 second press", pulses, 1);
    go_btn_n = 1'b1; cyc(3);

    sat_in = 1'b1;
    cyc(1);
    chk(led == '1 && !sw_run && !sw_clear, "R8 saturation entry", led, 1023);
    cnt = 1;
    while (led == '1) begin cyc(1); if (led == '1) cnt++; end
    chk(cnt == FLASH_DIV, "R8 on duration", cnt, FLASH_DIV);
    cnt = 1;
    while (led == '0 && cnt < 100) begin cyc(1); if (led == '0) cnt++; end
    chk(cnt == FLASH_DIV && led == '1, "R8 off duration", cnt, FLASH_DIV);

    sat_in = 1'b0; go_btn_n = 1'b0;
    cyc(5);
    ons = 0; stray = 1'b0;
    for (int k = 0; k < 2 * FLASH_DIV; k++) begin
      cyc(1);
      if (led == '1) ons++;
      if (sw_run || sw_clear || finish_pulse) stray = 1'b1;
    end
    chk(ons == FLASH_DIV && !stray, "R9 saturation persists", ons, FLASH_DIV);
    go_btn_n = 1'b1;

    cyc(1); #1 rst_btn_n = 1'b0; #1;
    chk_idle("R10 async reset from saturation");
    cyc(1); rst_btn_n = 1'b1; cyc(4);
    chk_idle("R1 idle after second reset");

    go_btn_n = 1'b0; cyc(6); go_btn_n = 1'b1;
    chk(cd_show, "R2 second start", cd_show, 1);
    cyc(20);
    sat_in = 1'b1; cyc(2);
    chk(cd_show && cd_digit == 4'd2 && led == '0, "R11 sat_in in countdown", cd_digit, 2);
    sat_in = 1'b0;
    #1 rst_btn_n = 1'b0; #1;
    chk_idle("R10 async reset from countdown");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule